// File: doc/BRIEF.md
# Indexed Clock-Synthesizer Register Port

This block is the byte-wide host register port of a video DAC that contains a clock synthesizer. The host reaches it through four ports: command/mask, read index, write index and data. A select input chooses between palette space and PLL register space. When the select is 1, the index and data ports address a small file of synthesizer entries. Most entries hold an M byte and an N byte. Each data access moves a byte phase from M to N, and after the N byte it moves on to the next entry. The read pointer and the write pointer are independent. Entries 0 and 1 are fixed clocks that cannot be written. Entry 14 is a single-byte control register.

The block drives the M, N1 and N2 fields of the programmable pixel clock (entry 2) to the synthesizer. The synthesized frequency is ref × (M+2) / (N1+2) / 2^N2, with a 14.31818 MHz reference. On the command port there is a hidden identification sequence: after the write-index port is read, the fourth command-port read returns a chip ID instead of the register. Palette RAM contents are not modelled, so palette-space data reads return zero.

Top module: `clksyn_regport`

## Requirements
- R1: Port codes on `acc_port`: 0 = command/mask, 1 = read index, 2 = write index, 3 = data. With `pll_sel`=0, index writes go to separate 8-bit palette index registers, data writes are ignored, data reads return 0x00, and the PLL pointers, entries and divider outputs are left unchanged.
- R2: With `pll_sel`=1, entries 0 and 1 read as M/N = 0x28/0x61 and 0x3D/0x62. Data writes aimed at them are discarded, but the write pointer still advances.
- R3: Writing the read-index port loads the read pointer and sets the byte phase to M. Each data read returns M and then N, and the index advances after the N byte. Eight reads from index 0 return entries 0 to 3 in order.
- R4: The write pointer loads and advances in the same way as the read pointer. The two pointers never disturb each other.
- R5: Entry 14 is a single 8-bit control byte. Any data access to it moves that pointer to index 15.
- R6: In every M/N entry from 2 upward, only bits 6:0 are stored. Bit 7 reads back as 0.
- R7: `pix_m` = entry 2 M[6:0], `pix_n1` = entry 2 N[4:0] and `pix_n2` = entry 2 N[6:5]. They change two clock edges after the access that wrote the byte, and they reset to M=0x28, N=0x61.
- R8: In PLL space, reading an index port returns the current pointer index (zero-extended) after any auto-advance.
- R9: After a read of the write-index port, command-port reads 1 to 3 return the normal register. Read 4 returns CHIP_ID (0x70, upper nibble 7). Read 5 is normal again.
- R10: Between the write-index read and the fourth command read, any access other than a command-port read cancels the identification sequence.
- R11: Read data appears on `rd_data` with `rd_valid` high exactly one cycle after a read access. `rd_valid` is low in every other cycle.
- R12: After reset the command register is 0x00 and the pixel mask is 0xFF. Entry 10 (memory clock) holds 0x4A/0x25, the control byte holds 0x00 and both PLL pointers are 0.
- R13: Pointer indices wrap from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_sel | input | 1 | 1 = PLL register space, 0 = palette space |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_port | input | 2 | Port code (see R1) |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| pix_m | output | 7 | Pixel-clock M field |
| pix_n1 | output | 5 | Pixel-clock N1 field |
| pix_n2 | output | 2 | Pixel-clock N2 post-divider field |

## Verification
Several access patterns exercise the pointer walk, and each one separates a different fault:
- A straight eight-byte read from index 0 distinguishes the byte order and the per-pair advance.
- A write burst over the fixed entries, followed by a read-back, separates "discarded" from "blocked pointer".
- A burst across entry 14 tells the single-byte step from the paired step.
- A burst at index 15 shows the wrap.

Command-read runs with and without an intervening access separate a correct fourth-read ID from an ID that arrives early, arrives late or survives a cancel. Palette-space traffic placed between PLL accesses shows whether the spaces are truly separate.

// File: rtl/clksyn_pkg.sv
`timescale 1ns/1ps
package clksyn_pkg;
  typedef enum logic [1:0] {
    PORT_CMD  = 2'd0,
    PORT_RIDX = 2'd1,
    PORT_WIDX = 2'd2,
    PORT_DATA = 2'd3
  } port_e;

  localparam int          RO_ENTRIES = 2;
  localparam logic [7:0]  FIX0_M = 8'h28;
  localparam logic [7:0]  FIX0_N = 8'h61;
  localparam logic [7:0]  FIX1_M = 8'h3D;
  localparam logic [7:0]  FIX1_N = 8'h62;
endpackage

// File: rtl/clksyn_ptr.sv
`timescale 1ns/1ps
module clksyn_ptr #(
  parameter int IDX_W    = 4,
  parameter int CTRL_IDX = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             phase
);
  localparam logic [IDX_W-1:0] CTRL = CTRL_IDX[IDX_W-1:0];

  logic single;
  assign single = (idx == CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      phase <= 1'b0;
    end else if (load) begin
      idx   <= load_val;
      phase <= 1'b0;
    end else if (step) begin
      if (phase || single) begin
        idx   <= idx + 1'b1;
        phase <= 1'b0;
      end else begin
        phase <= 1'b1;
      end
    end
  end

  p_load_phase_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> (phase == 1'b0 && idx == $past(load_val)));

  p_pair_step_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !load && phase) |=> (idx == $past(idx) + 1'b1 && !phase));

  p_ctrl_step_r5: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !phase && idx == CTRL) |=> (idx == $past(idx) + 1'b1 && !phase));
endmodule

// File: rtl/clksyn_regs.sv
`timescale 1ns/1ps
module clksyn_regs
  import clksyn_pkg::*;
#(
  parameter int         IDX_W      = 4,
  parameter int         CTRL_IDX   = 14,
  parameter int         PIX_IDX    = 2,
  parameter int         MCLK_IDX   = 10,
  parameter logic [6:0] PIX_M_RST  = 7'h28,
  parameter logic [6:0] PIX_N_RST  = 7'h61,
  parameter logic [6:0] MCLK_M_RST = 7'h4A,
  parameter logic [6:0] MCLK_N_RST = 7'h25,
  parameter logic [7:0] CTRL_RST   = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic             w_phase,
  input  logic [7:0]       w_data,
  input  logic [IDX_W-1:0] r_idx,
  input  logic             r_phase,
  output logic [7:0]       r_byte,
  output logic [6:0]       pix_m,
  output logic [4:0]       pix_n1,
  output logic [1:0]       pix_n2
);
  localparam int N_ENT = 1 << IDX_W;
  localparam logic [IDX_W-1:0] CTRL = CTRL_IDX[IDX_W-1:0];

  logic [6:0] m_q [N_ENT];
  logic [6:0] n_q [N_ENT];
  logic [7:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < N_ENT; e++) begin
        m_q[e] <= (e == PIX_IDX) ? PIX_M_RST : (e == MCLK_IDX) ? MCLK_M_RST : 7'h00;
        n_q[e] <= (e == PIX_IDX) ? PIX_N_RST : (e == MCLK_IDX) ? MCLK_N_RST : 7'h00;
      end
      ctrl_q <= CTRL_RST;
    end else if (we) begin
      if (w_idx == CTRL) ctrl_q <= w_data;
      else if (w_phase)  n_q[w_idx] <= w_data[6:0];
      else               m_q[w_idx] <= w_data[6:0];
    end
  end

  always_comb begin
    if (r_idx == IDX_W'(0))      r_byte = r_phase ? FIX0_N : FIX0_M;
    else if (r_idx == IDX_W'(1)) r_byte = r_phase ? FIX1_N : FIX1_M;
    else if (r_idx == CTRL)      r_byte = ctrl_q;
    else                         r_byte = {1'b0, (r_phase ? n_q[r_idx] : m_q[r_idx])};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_m  <= PIX_M_RST;
      pix_n1 <= PIX_N_RST[4:0];
      pix_n2 <= PIX_N_RST[6:5];
    end else begin
      pix_m  <= m_q[PIX_IDX];
      pix_n1 <= n_q[PIX_IDX][4:0];
      pix_n2 <= n_q[PIX_IDX][6:5];
    end
  end

  p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(we && w_idx == CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/clksyn_idseq.sv
`timescale 1ns/1ps
module clksyn_idseq #(
  parameter int ID_READ = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic acc,
  input  logic cmd_rd,
  input  logic widx_rd,
  output logic id_hit
);
  localparam int CW = $clog2(ID_READ + 1);
  localparam logic [CW-1:0] LAST = ID_READ[CW-1:0];

  logic [CW-1:0] cnt;

  assign id_hit = cmd_rd && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (acc) begin
      if (widx_rd)            cnt <= CW'(1);
      else if (cmd_rd) begin
        if (cnt == LAST)      cnt <= '0;
        else if (cnt != '0)   cnt <= cnt + 1'b1;
      end else                cnt <= '0;
    end
  end

  p_cancel_r10: assert property (@(posedge clk) disable iff (rst)
    (acc && !cmd_rd && !widx_rd) |=> (cnt == '0));

  p_arm_r9: assert property (@(posedge clk) disable iff (rst)
    (acc && widx_rd) |=> (cnt == CW'(1)));
endmodule

// File: rtl/clksyn_regport.sv
`timescale 1ns/1ps
module clksyn_regport
  import clksyn_pkg::*;
#(
  parameter int         IDX_W      = 4,
  parameter int         CTRL_IDX   = 14,
  parameter int         PIX_IDX    = 2,
  parameter int         MCLK_IDX   = 10,
  parameter int         ID_READ    = 4,
  parameter logic [7:0] CHIP_ID    = 8'h70,
  parameter logic [7:0] CMD_RST    = 8'h00,
  parameter logic [7:0] MASK_RST   = 8'hFF,
  parameter logic [6:0] PIX_M_RST  = 7'h28,
  parameter logic [6:0] PIX_N_RST  = 7'h61,
  parameter logic [6:0] MCLK_M_RST = 7'h4A,
  parameter logic [6:0] MCLK_N_RST = 7'h25
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pll_sel,
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic [1:0] acc_port,
  input  logic [7:0] acc_wdata,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic [6:0] pix_m,
  output logic [4:0] pix_n1,
  output logic [1:0] pix_n2
);
  localparam logic [IDX_W-1:0] PIX = PIX_IDX[IDX_W-1:0];

  port_e      port;
  logic       is_rd, is_wr;
  logic [IDX_W-1:0] r_idx, w_idx;
  logic       r_phase, w_phase;
  logic       r_load, r_step, w_load, w_step, reg_we;
  logic [7:0] r_byte, rd_next;
  logic [7:0] cmd_q, mask_q, pal_ridx, pal_widx;
  logic       id_hit;

  assign port   = port_e'(acc_port);
  assign is_rd  = acc_valid && !acc_write;
  assign is_wr  = acc_valid &&  acc_write;
  assign r_load = is_wr && pll_sel && (port == PORT_RIDX);
  assign w_load = is_wr && pll_sel && (port == PORT_WIDX);
  assign r_step = is_rd && pll_sel && (port == PORT_DATA);
  assign w_step = is_wr && pll_sel && (port == PORT_DATA);
  assign reg_we = w_step && (w_idx >= IDX_W'(RO_ENTRIES));

  clksyn_ptr #(.IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX)) u_rptr (
    .clk(clk), .rst(rst), .load(r_load), .load_val(acc_wdata[IDX_W-1:0]),
    .step(r_step), .idx(r_idx), .phase(r_phase));

  clksyn_ptr #(.IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX)) u_wptr (
    .clk(clk), .rst(rst), .load(w_load), .load_val(acc_wdata[IDX_W-1:0]),
    .step(w_step), .idx(w_idx), .phase(w_phase));

  clksyn_regs #(
    .IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX), .PIX_IDX(PIX_IDX), .MCLK_IDX(MCLK_IDX),
    .PIX_M_RST(PIX_M_RST), .PIX_N_RST(PIX_N_RST),
    .MCLK_M_RST(MCLK_M_RST), .MCLK_N_RST(MCLK_N_RST), .CTRL_RST(8'h00)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .w_idx(w_idx), .w_phase(w_phase),
    .w_data(acc_wdata), .r_idx(r_idx), .r_phase(r_phase), .r_byte(r_byte),
    .pix_m(pix_m), .pix_n1(pix_n1), .pix_n2(pix_n2));

  clksyn_idseq #(.ID_READ(ID_READ)) u_id (
    .clk(clk), .rst(rst), .acc(acc_valid),
    .cmd_rd(is_rd && port == PORT_CMD),
    .widx_rd(is_rd && port == PORT_WIDX),
    .id_hit(id_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= CMD_RST;
      mask_q   <= MASK_RST;
      pal_ridx <= 8'h00;
      pal_widx <= 8'h00;
    end else if (is_wr) begin
      case (port)
        PORT_CMD:  if (pll_sel) cmd_q <= acc_wdata; else mask_q <= acc_wdata;
        PORT_RIDX: if (!pll_sel) pal_ridx <= acc_wdata;
        PORT_WIDX: if (!pll_sel) pal_widx <= acc_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (port)
      PORT_CMD:  rd_next = id_hit ? CHIP_ID : (pll_sel ? cmd_q : mask_q);
      PORT_RIDX: rd_next = pll_sel ? {{(8-IDX_W){1'b0}}, r_idx} : pal_ridx;
      PORT_WIDX: rd_next = pll_sel ? {{(8-IDX_W){1'b0}}, w_idx} : pal_widx;
      default:   rd_next = pll_sel ? r_byte : 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= 8'h00;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= is_rd;
      if (is_rd) rd_data <= rd_next;
    end
  end

  p_rd_latency_r11: assert property (@(posedge clk) disable iff (rst)
    is_rd |=> rd_valid);

  p_no_rd_r11: assert property (@(posedge clk) disable iff (rst)
    !is_rd |=> !rd_valid);

  p_pix_m_r7: assert property (@(posedge clk) disable iff (rst)
    (w_step && !w_load && w_idx == PIX && !w_phase) |-> ##2 (pix_m == $past(acc_wdata[6:0], 2)));

  p_pal_iso_r1: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !pll_sel) |=> ($stable(r_idx) && $stable(w_idx)));
endmodule

// File: tb/sim_clksyn_regport.sv
`timescale 1ns/1ps
module sim_clksyn_regport;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pll_sel = 1'b1;
  logic       acc_valid = 1'b0;
  logic       acc_write = 1'b0;
  logic [1:0] acc_port = 2'd0;
  logic [7:0] acc_wdata = 8'h00;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic [6:0] pix_m;
  logic [4:0] pix_n1;
  logic [1:0] pix_n2;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [1:0] P_CMD = 2'd0, P_RIDX = 2'd1, P_WIDX = 2'd2, P_DATA = 2'd3;

  always #2.5 clk = ~clk;

  clksyn_regport u0 (
    .clk(clk), .rst(rst), .pll_sel(pll_sel), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_port(acc_port), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .pix_m(pix_m),
    .pix_n1(pix_n1), .pix_n2(pix_n2));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] p, input logic s, input logic [7:0] d);
    pll_sel = s; acc_valid = 1'b1; acc_write = 1'b1; acc_port = p; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] p, input logic s, output logic [7:0] q);
    pll_sel = s; acc_valid = 1'b1; acc_write = 1'b0; acc_port = p; acc_wdata = 8'h00;
    @(negedge clk);
    q = rd_data;
    acc_valid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] q;
    chk("R12 rd_valid after reset", {7'd0, rd_valid}, 8'h00);
    chk("R7 reset pix_m", {1'b0, pix_m}, 8'h28);
    chk("R7 reset pix_n1", {3'b0, pix_n1}, 8'h01);
    chk("R7 reset pix_n2", {6'b0, pix_n2}, 8'h03);
    rd(P_CMD, 1'b1, q);  chk("R12 command reset", q, 8'h00);
    rd(P_CMD, 1'b0, q);  chk("R12 mask reset", q, 8'hFF);
    rd(P_RIDX, 1'b1, q); chk("R12 read pointer reset", q, 8'h00);
    rd(P_DATA, 1'b1, q); chk("R12 entry0 M at reset", q, 8'h28);
    wr(P_RIDX, 1'b1, 8'h0A);
    rd(P_DATA, 1'b1, q); chk("R12 mclk M reset", q, 8'h4A);
    rd(P_DATA, 1'b1, q); chk("R12 mclk N reset", q, 8'h25);
    wr(P_RIDX, 1'b1, 8'h0E);
    rd(P_DATA, 1'b1, q); chk("R12 control reset", q, 8'h00);
  endtask

  task automatic t_walk();
    logic [7:0] q;
    logic [7:0] exp [8] = '{8'h28, 8'h61, 8'h3D, 8'h62, 8'h28, 8'h61, 8'h00, 8'h00};
    wr(P_RIDX, 1'b1, 8'h00);
    for (int i = 0; i < 8; i++) begin
      rd(P_DATA, 1'b1, q);
      chk($sformatf("R3 walk byte %0d", i), q, exp[i]);
    end
    rd(P_RIDX, 1'b1, q); chk("R8 read index after walk", q, 8'h04);
    wr(P_RIDX, 1'b1, 8'h01);
    rd(P_DATA, 1'b1, q); rd(P_DATA, 1'b1, q);
    wr(P_RIDX, 1'b1, 8'h01);
    rd(P_DATA, 1'b1, q); chk("R3 index load restarts at M", q, 8'h3D);
  endtask

  task automatic t_readonly();
    logic [7:0] q;
    wr(P_WIDX, 1'b1, 8'h00);
    wr(P_DATA, 1'b1, 8'hAA); wr(P_DATA, 1'b1, 8'hBB);
    wr(P_DATA, 1'b1, 8'hCC); wr(P_DATA, 1'b1, 8'hDD);
    rd(P_WIDX, 1'b1, q); chk("R2 write pointer advanced past fixed entries", q, 8'h02);
    wr(P_RIDX, 1'b1, 8'h00);
    rd(P_DATA, 1'b1, q); chk("R2 entry0 M unchanged", q, 8'h28);
    rd(P_DATA, 1'b1, q); chk("R2 entry0 N unchanged", q, 8'h61);
    rd(P_DATA, 1'b1, q); chk("R2 entry1 M unchanged", q, 8'h3D);
    rd(P_DATA, 1'b1, q); chk("R2 entry1 N unchanged", q, 8'h62);
  endtask

  task automatic t_pixclk();
    logic [7:0] q;
    wr(P_RIDX, 1'b1, 8'h03);
    wr(P_WIDX, 1'b1, 8'h02);
    wr(P_DATA, 1'b1, 8'hC5);
    wr(P_DATA, 1'b1, 8'hB3);
    idle();
    chk("R7 pix_m", {1'b0, pix_m}, 8'h45);
    chk("R7 pix_n1", {3'b0, pix_n1}, 8'h13);
    chk("R7 pix_n2", {6'b0, pix_n2}, 8'h01);
    rd(P_RIDX, 1'b1, q); chk("R4 read pointer untouched by writes", q, 8'h03);
    rd(P_WIDX, 1'b1, q); chk("R4 write pointer after pair", q, 8'h03);
    wr(P_RIDX, 1'b1, 8'h02);
    rd(P_DATA, 1'b1, q); chk("R6 M bit7 dropped", q, 8'h45);
    rd(P_DATA, 1'b1, q); chk("R6 N bit7 dropped", q, 8'h33);
    rd(P_WIDX, 1'b1, q); chk("R4 write pointer untouched by reads", q, 8'h03);
  endtask

  task automatic t_control();
    logic [7:0] q;
    wr(P_WIDX, 1'b1, 8'h0E);
    wr(P_DATA, 1'b1, 8'h9C);
    rd(P_WIDX, 1'b1, q); chk("R5 single-byte write step", q, 8'h0F);
    wr(P_RIDX, 1'b1, 8'h0D);
    rd(P_DATA, 1'b1, q); rd(P_DATA, 1'b1, q);
    rd(P_DATA, 1'b1, q); chk("R5 control byte all 8 bits", q, 8'h9C);
    rd(P_RIDX, 1'b1, q); chk("R5 single-byte read step", q, 8'h0F);
  endtask

  task automatic t_wrap();
    logic [7:0] q;
    wr(P_WIDX, 1'b1, 8'h0F);
    wr(P_DATA, 1'b1, 8'h11); wr(P_DATA, 1'b1, 8'h22);
    rd(P_WIDX, 1'b1, q); chk("R13 write index wrap", q, 8'h00);
    wr(P_RIDX, 1'b1, 8'h0F);
    rd(P_DATA, 1'b1, q); chk("R13 entry15 M", q, 8'h11);
    rd(P_DATA, 1'b1, q); chk("R13 entry15 N", q, 8'h22);
    rd(P_RIDX, 1'b1, q); chk("R13 read index wrap", q, 8'h00);
  endtask

  task automatic t_palette();
    logic [7:0] q;
    wr(P_RIDX, 1'b1, 8'h05);
    wr(P_WIDX, 1'b1, 8'h07);
    wr(P_RIDX, 1'b0, 8'h55);
    wr(P_WIDX, 1'b0, 8'h66);
    wr(P_DATA, 1'b0, 8'h77);
    wr(P_CMD,  1'b0, 8'h3C);
    rd(P_RIDX, 1'b0, q); chk("R1 palette read index", q, 8'h55);
    rd(P_WIDX, 1'b0, q); chk("R1 palette write index", q, 8'h66);
    rd(P_DATA, 1'b0, q); chk("R1 palette data reads zero", q, 8'h00);
    rd(P_CMD,  1'b0, q); chk("R1 mask register", q, 8'h3C);
    rd(P_RIDX, 1'b1, q); chk("R1 PLL read index kept", q, 8'h05);
    rd(P_WIDX, 1'b1, q); chk("R1 PLL write index kept", q, 8'h07);
    chk("R1 pix_m kept", {1'b0, pix_m}, 8'h45);
  endtask

  task automatic t_chipid();
    logic [7:0] q;
    wr(P_CMD, 1'b1, 8'h12);
    rd(P_WIDX, 1'b1, q);
    for (int i = 1; i <= 5; i++) begin
      rd(P_CMD, 1'b1, q);
      chk($sformatf("R9 command read %0d", i), q, (i == 4) ? 8'h70 : 8'h12);
    end
  endtask

  task automatic t_cancel();
    logic [7:0] q;
    rd(P_WIDX, 1'b1, q);
    rd(P_CMD, 1'b1, q); rd(P_CMD, 1'b1, q);
    rd(P_RIDX, 1'b1, q);
    for (int i = 1; i <= 4; i++) begin
      rd(P_CMD, 1'b1, q);
      chk($sformatf("R10 read %0d after cancel by index read", i), q, 8'h12);
    end
    rd(P_WIDX, 1'b1, q);
    rd(P_CMD, 1'b1, q); rd(P_CMD, 1'b1, q); rd(P_CMD, 1'b1, q);
    idle();
    wr(P_DATA, 1'b0, 8'h00);
    rd(P_CMD, 1'b1, q); chk("R10 fourth read after cancel by write", q, 8'h12);
  endtask

  task automatic t_latency();
    logic [7:0] q;
    rd(P_CMD, 1'b1, q);
    chk("R11 rd_valid in cycle after read", {7'd0, rd_valid}, 8'h01);
    idle();
    chk("R11 rd_valid low when idle", {7'd0, rd_valid}, 8'h00);
    wr(P_CMD, 1'b1, 8'h12);
    chk("R11 rd_valid low after write", {7'd0, rd_valid}, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_walk();
    t_readonly();
    t_pixclk();
    t_control();
    t_wrap();
    t_palette();
    t_chipid();
    t_cancel();
    t_latency();
    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule